// File: doc/BRIEF.md
# Double-Buffered PWM Output Generator

This block makes a pulse-width modulated output from a free-running timebase. A prescaler divides the input clock by 1, 8, 64 or 256. The counter then climbs from zero up to a programmed period value and wraps back to zero. The output is high while the count is below the active duty value and low from there on.

Software never writes the active duty value directly while the PWM runs. It writes a buffer register whenever it likes, and the buffer is copied into the active duty register only at the end of a period. A duty change can therefore never cut a pulse short or stretch it mid-period.

A second PWM mode watches a fault input. When the fault input is asserted, the output is forced low and a sticky flag is latched, and the output stays low until software rewrites the control register. A one-clock interrupt pulse marks every period completion.

Top module: `pwm_gen_top`

## Requirements
- R1: With period register value P, the counter visits 0..P and returns to 0 on the advance after it equals P, so one PWM period spans P+1 counts.
- R2: While running in a PWM mode without a fault, `pwm_out` is high exactly when the count is below the active duty value.
- R3: The duty buffer (address 1) may be written at any time. Its value reaches the active duty register (address 2) only on the advance where the count equals P. The first period after enabling uses the value loaded into address 2 beforehand.
- R4: In the PWM modes, writes to address 2 are ignored and reads return the active duty. In any other mode, address 2 can be written.
- R5: An active duty of zero keeps `pwm_out` low for the whole period.
- R6: An active duty greater than P keeps `pwm_out` high for the whole period.
- R7: An active duty equal to P drives `pwm_out` low for exactly one count value (the count P) and high for all others.
- R8: Control register (address 3) bits [4:3] select the prescale: 0 selects /1, 1 selects /8, 2 selects /64 and 3 selects /256. The counter advances once per that many clocks. The timebase runs only while enable bit 5 is set. With bit 5 clear, the counter stays at zero and the output is low.
- R9: `period_irq` is high for one clock at the start of each new period, in the cycle after the advance where the count equalled P.
- R10: In mode 3'b111 (control bits [2:0]), a high `fault_in` forces `pwm_out` low at once and sets sticky flag bit 6 of the control register. The output stays low until the control register is written, and that write clears the flag. In mode 3'b110, `fault_in` has no effect.
- R11: With mode codes other than 3'b110 and 3'b111, the output stays low and no interrupt is raised, even when enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 period, 1 duty buffer, 2 active duty, 3 control |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | CNT_W | Read data (combinational) |
| fault_in | input | 1 | Fault request |
| pwm_out | output | 1 | PWM output |
| period_irq | output | 1 | One-clock pulse per completed period |

## Verification
The bench goes after the three duty boundaries. A design with an off-by-one compare would show a full-high period at duty zero, an extra low count at duty equal to period, or a missing high count when duty exceeds the period. Duty changes are made while the PWM runs, and the expected waveform is built period by period. A design that copied the buffer early would show the new duty inside the running period, and one that copied it late would show the old duty for an extra period.

Each prescale value is run long enough to see several wraps, which exposes a divider that is one clock off. The fault tests check two things. First, the flag must survive a period boundary until the control write, so a non-sticky flag would let the output come back by itself. Second, the same fault pulse in the plain PWM mode must leave the output untouched.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

   localparam int REG_ADDR_W  = 2;
   localparam int MODE_W      = 3;
   localparam int PRESC_SEL_W = 2;
   localparam int PRESC_CNT_W = 8;

   localparam logic [REG_ADDR_W-1:0] ADR_PERIOD = 2'd0;
   localparam logic [REG_ADDR_W-1:0] ADR_DBUF   = 2'd1;
   localparam logic [REG_ADDR_W-1:0] ADR_DACT   = 2'd2;
   localparam logic [REG_ADDR_W-1:0] ADR_CTRL   = 2'd3;

   localparam logic [MODE_W-1:0] MODE_PWM     = 3'b110;
   localparam logic [MODE_W-1:0] MODE_PWM_FLT = 3'b111;

   // control word layout, low bits first: mode, prescale select, enable, fault flag
   typedef struct packed {
      logic                   flt;
      logic                   en;
      logic [PRESC_SEL_W-1:0] sel;
      logic [MODE_W-1:0]      mode;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   // terminal value of the prescale counter for each select code
   function automatic logic [PRESC_CNT_W-1:0] presc_limit(input logic [PRESC_SEL_W-1:0] sel);
      case (sel)
         2'd0:    presc_limit = 8'd0;
         2'd1:    presc_limit = 8'd7;
         2'd2:    presc_limit = 8'd63;
         default: presc_limit = 8'd255;
      endcase
   endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
   import pwm_gen_pkg::*;
#(
   parameter bit USE_PRESCALE = 1'b1
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   run,
   input  logic [PRESC_SEL_W-1:0] sel,
   output logic                   tick
);

   generate
      if (USE_PRESCALE) begin : g_div
         logic [PRESC_CNT_W-1:0] pre_q;
         logic [PRESC_CNT_W-1:0] lim;

         assign lim  = presc_limit(sel);
         assign tick = run && (pre_q == lim);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            pre_q <= '0;
            else if (!run || tick) pre_q <= '0;
            else                   pre_q <= pre_q + 1'b1;
         end

         // R8: after a tick with a divide ratio above one, the next clock carries no tick
         p_tick_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && lim != '0) |=> (!tick || lim == '0));
      end else begin : g_nodiv
         logic unused_sel;
         assign unused_sel = ^sel;
         assign tick       = run;
      end
   endgenerate

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
   parameter int CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] count,
   output logic             match
);

   logic [CNT_W-1:0] cnt_q;

   assign count = cnt_q;
   assign match = tick && (cnt_q == period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (!run)  cnt_q <= '0;
      else if (match) cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_q + 1'b1;
   end

   // R1: the count returns to zero right after a period match
   p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> (count == '0));

   // R8: with the timebase running, the count moves only on a prescale tick
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> (count == $past(count)) || !run);

   // R8: a stopped timebase sits at zero
   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (count == '0) || run);

endmodule

// File: rtl/pwm_reg_bank.sv
module pwm_reg_bank
   import pwm_gen_pkg::*;
#(
   parameter int CNT_W = 16
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]      wr_data,
   input  logic [REG_ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]      rd_data,
   input  logic                  match,
   input  logic                  fault_hit,
   output logic [CNT_W-1:0]      period,
   output logic [CNT_W-1:0]      duty_act,
   output ctrl_t                 ctrl,
   output logic                  pwm_mode
);

   logic [CNT_W-1:0] period_q;
   logic [CNT_W-1:0] dbuf_q;
   logic [CNT_W-1:0] dact_q;
   ctrl_t            ctrl_q;
   logic             wr_ctrl;
   logic             wr_dact;

   assign wr_ctrl  = wr_en && (wr_addr == ADR_CTRL);
   assign wr_dact  = wr_en && (wr_addr == ADR_DACT);
   assign pwm_mode = (ctrl_q.mode == MODE_PWM) || (ctrl_q.mode == MODE_PWM_FLT);
   assign period   = period_q;
   assign duty_act = dact_q;
   assign ctrl     = ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '0;
         dbuf_q   <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADR_PERIOD) period_q <= wr_data;
         if (wr_addr == ADR_DBUF)   dbuf_q   <= wr_data;
      end
   end

   // active duty: loaded from the buffer at a period match, otherwise writable only outside PWM modes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    dact_q <= '0;
      else if (match)                dact_q <= dbuf_q;
      else if (wr_dact && !pwm_mode) dact_q <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.mode <= wr_data[MODE_W-1:0];
            ctrl_q.sel  <= wr_data[MODE_W +: PRESC_SEL_W];
            ctrl_q.en   <= wr_data[MODE_W+PRESC_SEL_W];
         end
         if (fault_hit)    ctrl_q.flt <= 1'b1;
         else if (wr_ctrl) ctrl_q.flt <= 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADR_PERIOD: rd_data = period_q;
         ADR_DBUF:   rd_data = dbuf_q;
         ADR_DACT:   rd_data = dact_q;
         default:    rd_data[CTRL_W-1:0] = ctrl_q;
      endcase
   end

   // R3: in a PWM mode the active duty changes only at a period match
   p_dact_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_mode && !match) |=> $stable(duty_act));

   // R4: a write to the active duty in a PWM mode leaves it unchanged
   p_dact_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_mode && wr_dact && !match) |=> (duty_act == $past(duty_act)));

   // R10: the fault flag never drops without a control write
   p_flt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.flt && !wr_ctrl) |=> ctrl.flt);

endmodule

// File: rtl/pwm_gen_top.sv
module pwm_gen_top
   import pwm_gen_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int FAULT_SYNC   = 0,
   parameter bit USE_PRESCALE = 1'b1
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]      wr_data,
   input  logic [REG_ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]      rd_data,
   input  logic                  fault_in,
   output logic                  pwm_out,
   output logic                  period_irq
);

   generate
      if (CNT_W < CTRL_W) begin : g_bad_width
         $error("CNT_W must hold the control word");
      end
      if (FAULT_SYNC < 0 || FAULT_SYNC > 4) begin : g_bad_sync
         $error("FAULT_SYNC must lie in 0..4");
      end
   endgenerate

   logic [CNT_W-1:0] period;
   logic [CNT_W-1:0] duty_act;
   logic [CNT_W-1:0] count;
   ctrl_t            ctrl;
   logic             pwm_mode;
   logic             run;
   logic             tick;
   logic             match;
   logic             fault_s;
   logic             fault_hit;
   logic             irq_q;

   generate
      if (FAULT_SYNC == 0) begin : g_fault_direct
         assign fault_s = fault_in;
      end else begin : g_fault_sync
         logic [FAULT_SYNC-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[FAULT_SYNC-1:0], fault_in} >> 0;
         end
         assign fault_s = sync_q[FAULT_SYNC-1];
      end
   endgenerate

   assign run       = pwm_mode && ctrl.en;
   assign fault_hit = (ctrl.mode == MODE_PWM_FLT) && fault_s;

   pwm_reg_bank #(.CNT_W(CNT_W)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .match     (match),
      .fault_hit (fault_hit),
      .period    (period),
      .duty_act  (duty_act),
      .ctrl      (ctrl),
      .pwm_mode  (pwm_mode)
   );

   pwm_prescaler #(.USE_PRESCALE(USE_PRESCALE)) presc_i (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .sel   (ctrl.sel),
      .tick  (tick)
   );

   pwm_timebase #(.CNT_W(CNT_W)) tb_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .tick   (tick),
      .period (period),
      .count  (count),
      .match  (match)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= match;
   end

   assign period_irq = irq_q;
   assign pwm_out    = run && !ctrl.flt && !fault_hit && (count < duty_act);

   // R11: outside the PWM modes the pin is low
   p_off_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_mode |-> !pwm_out);

   // R10: a latched fault keeps the pin low
   p_fault_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.flt |-> !pwm_out);

   // R9: the interrupt pulse falls on the first count of a period
   p_irq_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      period_irq |-> (count == '0));

   // R6: a duty above the period holds the pin high while running fault-free
   p_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !ctrl.flt && !fault_hit && duty_act > period) |-> pwm_out);

   // R5: a zero duty never lets the pin rise
   p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_act == '0) |-> !pwm_out);

endmodule

// File: tb/pwm_gen_top_tb.sv
module pwm_gen_top_tb_top;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic [1:0]   rd_addr = '0;
   logic [W-1:0] rd_data;
   logic         fault_in = 1'b0;
   logic         pwm_out;
   logic         period_irq;

   always #4 clk = ~clk;

   pwm_gen_top #(.CNT_W(W)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .fault_in   (fault_in),
      .pwm_out    (pwm_out),
      .period_irq (period_irq)
   );

   typedef struct {
      logic  pwm;
      logic  irq;
      int    idx;
      string req;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   bit   finished = 1'b0;

   // monitor: one expected item per cycle, sampled mid high phase
   always @(posedge clk) begin
      exp_t e;
      #2;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         checks++;
         if (pwm_out !== e.pwm || period_irq !== e.irq) begin
            errors++;
            $display("FAIL %s cycle %0d: pwm/irq actual %b%b expected %b%b",
                     e.req, e.idx, pwm_out, period_irq, e.pwm, e.irq);
         end
      end
   end

   task automatic chk(input string req, input int act, input int expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   task automatic wr(input logic [1:0] a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input int expv, input string req);
      rd_addr = a;
      #1;
      chk(req, int'(rd_data), expv);
   endtask

   function automatic int div_of(input int sel);
      case (sel)
         0: return 1;
         1: return 8;
         2: return 64;
         default: return 256;
      endcase
   endfunction

   // driver: program, enable, push the expected waveform for nper periods
   task automatic run_case(input int p, input int init, input int bufv,
                           input int sel, input int nper, input string req);
      int div;
      int n;
      div = div_of(sel);
      n   = nper * div * (p + 1);
      wr(2'd3, 0);
      wr(2'd0, p);
      wr(2'd2, init);
      wr(2'd1, bufv);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd3; wr_data = W'((1 << 5) | (sel << 3) | 6);
      for (int k = 0; k < n; k++) begin
         exp_t e;
         int c;
         int j;
         int d;
         c = (k / div) % (p + 1);
         j = (k / div) / (p + 1);
         d = (j == 0) ? init : bufv;
         e.pwm = (c < d);
         e.irq = (k > 0) && (k % (div * (p + 1)) == 0);
         e.idx = k;
         e.req = req;
         exp_q.push_back(e);
      end
      @(negedge clk);
      wr_en = 1'b0;
      wait (exp_q.size() == 0);
      @(negedge clk);
   endtask

   task automatic quiet(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk({req, " pwm"}, int'(pwm_out), 0);
         chk({req, " irq"}, int'(period_irq), 0);
      end
   endtask

   task automatic report;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         report();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      chk("R8 reset pwm", int'(pwm_out), 0);
      chk("R9 reset irq", int'(period_irq), 0);
      rd_chk(2'd3, 0, "R8 reset ctrl");
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3: period 7 gives 8 counts, initial duty 3 then buffered 5
      run_case(7, 3, 5, 0, 3, "R1/R2/R3 p7");
      // R4: write to active duty ignored while in PWM mode
      wr(2'd2, 'h55);
      rd_chk(2'd2, 5, "R4 read-only in PWM");
      // R11: mode off, pin low; active duty writable again
      wr(2'd3, (1 << 5) | 1);
      wr(2'd2, 'h33);
      rd_chk(2'd2, 'h33, "R4 writable when off");
      quiet(20, "R11 mode 001");
      // R8: PWM mode with enable clear stays idle despite duty 0x33
      wr(2'd3, 6);
      quiet(20, "R8 disabled");

      // R5 R6: duty zero then duty above period
      run_case(4, 0, 9, 0, 3, "R5/R6 bounds");
      // R7: duty equal to period
      run_case(4, 4, 4, 0, 3, "R7 equal");
      // R3: shrink duty while running
      run_case(5, 6, 2, 0, 3, "R3 shrink");
      // R8 R9: prescale ratios
      run_case(3, 2, 1, 1, 3, "R8/R9 div8");
      run_case(1, 1, 2, 2, 3, "R8/R9 div64");
      run_case(0, 1, 0, 3, 3, "R8/R9 div256");

      // R10: fault mode
      wr(2'd3, 0);
      wr(2'd0, 7);
      wr(2'd2, 9);
      wr(2'd1, 9);
      wr(2'd3, (1 << 5) | 7);
      repeat (3) @(negedge clk);
      chk("R10 high before fault", int'(pwm_out), 1);
      fault_in = 1'b1;
      #1;
      chk("R10 immediate low", int'(pwm_out), 0);
      @(negedge clk);
      fault_in = 1'b0;
      #1;
      chk("R10 low after fault", int'(pwm_out), 0);
      rd_chk(2'd3, 'h67, "R10 flag set");
      repeat (20) @(negedge clk);
      chk("R10 still low", int'(pwm_out), 0);
      wr(2'd3, (1 << 5) | 7);
      #1;
      rd_chk(2'd3, 'h27, "R10 flag cleared");
      chk("R10 released", int'(pwm_out), 1);
      // R10: plain PWM mode ignores fault
      wr(2'd3, (1 << 5) | 6);
      fault_in = 1'b1;
      #1;
      chk("R10 ignored pwm", int'(pwm_out), 1);
      @(negedge clk);
      fault_in = 1'b0;
      #1;
      chk("R10 ignored after", int'(pwm_out), 1);
      rd_chk(2'd3, 'h26, "R10 no flag in mode 110");

      finished = 1'b1;
      report();
      $finish;
   end

endmodule